// File: doc/BRIEF.md
# Iterative Integer Divider with Condition Flags

This block divides integers over many cycles. It covers four operations: unsigned and signed division of a LONG_W-bit dividend by a LONG_W/2-bit divisor (the word forms), and unsigned and signed division of a 2*LONG_W-bit dividend by a LONG_W-bit divisor (the long forms). Each operation produces one quotient bit per clock. The core restores on a negative trial subtraction and works on magnitudes. Signs are applied when the operation finishes.

The block does not read a register file. The caller presents the operands and two destination indices with a one-cycle `start`. The block then produces register writes on a single write port, together with the N, Z, V and C flags. On a zero divisor it raises a one-cycle exception request instead of dividing. Writes are suppressed on overflow and on a zero divisor, so the caller's registers keep their old contents. A long-form result takes two write cycles, remainder first, so that the quotient wins when both indices name the same register.

Top module: `iter_divider`

## Requirements
- R1: `op[1]`=1 selects a long form and `op[0]`=1 selects a signed form. `start` is accepted only while `busy` is low. A `start` pulse during a running operation has no effect on its result and raises no request.
- R2: A zero divisor raises `div0_req` and `done` together, for one cycle, in the cycle after the start edge. Only `divisor[LONG_W/2-1:0]` counts in the word forms; all LONG_W bits count in the long forms. No write follows, and all four flags keep their values.
- R3: A word form without overflow makes one write to `quot_idx`. The written value holds the remainder in bits LONG_W-1:LONG_W/2 and the quotient in bits LONG_W/2-1:0.
- R4: The unsigned word form overflows when the quotient exceeds 2^(LONG_W/2)-1. The signed word form overflows when the quotient lies outside the signed LONG_W/2-bit range.
- R5: On overflow, V=1, C=0 and Z=0, N keeps its previous value, and no register is written.
- R6: C is 0 after every operation that is not a divide-by-zero.
- R7: In the long forms the dividend is `{dvd_hi, dvd_lo}`. Overflow is judged against the unsigned or signed LONG_W-bit range.
- R8: A long form without overflow writes the remainder to `rem_idx` in the `done` cycle, then the quotient to `quot_idx` in the next cycle. When the two indices are equal, the quotient is the value that stays.
- R9: Without overflow, N is the top bit of the quotient (bit LONG_W/2-1 in the word forms, bit LONG_W-1 in the long forms), Z=1 exactly when that quotient is zero, and V=0.
- R10: Signed division truncates toward zero, and a nonzero remainder has the sign of the dividend.
- R11: `done` rises in the cycle after the (LONG_W+1)th rising edge following the start edge in the word forms, and after the (2*LONG_W+1)th in the long forms.
- R12: After reset, `busy`, `done`, `div0_req`, `wr_en` and all four flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin an operation (sampled while idle) |
| op | input | 2 | Bit 1: long form; bit 0: signed |
| dvd_hi | input | LONG_W | Upper dividend half (long forms only) |
| dvd_lo | input | LONG_W | Lower dividend half, or the whole word-form dividend |
| divisor | input | LONG_W | Divisor; low LONG_W/2 bits in the word forms |
| quot_idx | input | IDX_W | Destination index for the quotient or the packed word result |
| rem_idx | input | IDX_W | Destination index for the long-form remainder |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse; flags are valid |
| div0_req | output | 1 | One-cycle divide-by-zero exception request |
| wr_en | output | 1 | Register write strobe |
| wr_idx | output | IDX_W | Register write index |
| wr_data | output | LONG_W | Register write data |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_v | output | 1 | Overflow flag |
| flag_c | output | 1 | Carry flag |

## Verification
Any wrong internal state shows up at the ports within one operation. A wrong magnitude, a dropped quotient bit or a lost sign fix changes the written register or the N and Z flags in the `done` cycle. A miscounted iteration moves `done` off its fixed latency. A wrong overflow bound shows either as a write that should not happen or as a missing one. A swapped write order leaves the remainder in a register whose two indices coincide. The bench sweeps every operand pair of both word forms in an 8-bit configuration and a large mixed set of long-form operands. It checks every write and flag against arithmetic done in the bench, one operation after another.

// File: rtl/iterdiv_pkg.sv
package iterdiv_pkg;

   // op encoding bits
   localparam int OP_SIGNED_BIT = 0;
   localparam int OP_LONG_BIT   = 1;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RUN  = 2'd1,
      ST_FIX  = 2'd2,
      ST_WRQ  = 2'd3
   } div_state_e;

endpackage

// File: rtl/iterdiv_prep.sv
module iterdiv_prep
   import iterdiv_pkg::*;
#(
   parameter int LONG_W = 32
) (
   input  logic [1:0]          op,
   input  logic [LONG_W-1:0]   hi,
   input  logic [LONG_W-1:0]   lo,
   input  logic [LONG_W-1:0]   dsr,
   output logic [2*LONG_W-1:0] num_mag,
   output logic [LONG_W-1:0]   dsr_mag,
   output logic                neg_quo,
   output logic                neg_rem,
   output logic                dsr_zero
);
   localparam int SW = LONG_W / 2;

   logic              is_sgn;
   logic              dvd_neg;
   logic              dsr_neg;
   logic [LONG_W-1:0] lo_mag;
   logic [SW-1:0]     dsr_s;
   logic [2*LONG_W-1:0] full;

   always_comb begin
      is_sgn = op[OP_SIGNED_BIT];
      full   = {hi, lo};
      dsr_s  = dsr[SW-1:0];
      lo_mag = '0;
      if (op[OP_LONG_BIT]) begin
         dvd_neg = is_sgn & hi[LONG_W-1];
         dsr_neg = is_sgn & dsr[LONG_W-1];
         num_mag = dvd_neg ? -full : full;
         dsr_mag = dsr_neg ? -dsr : dsr;
      end else begin
         dvd_neg = is_sgn & lo[LONG_W-1];
         dsr_neg = is_sgn & dsr_s[SW-1];
         lo_mag  = dvd_neg ? -lo : lo;
         // dividend aligned high so LONG_W steps suffice
         num_mag = {lo_mag, {LONG_W{1'b0}}};
         dsr_mag = {{SW{1'b0}}, (dsr_neg ? -dsr_s : dsr_s)};
      end
      neg_quo  = dvd_neg ^ dsr_neg;
      neg_rem  = dvd_neg;
      dsr_zero = (dsr_mag == '0);
   end

endmodule

// File: rtl/iterdiv_step.sv
module iterdiv_step #(
   parameter int LONG_W = 32
) (
   input  logic [LONG_W-1:0]   rem_in,
   input  logic [2*LONG_W-1:0] num_in,
   input  logic [LONG_W-1:0]   dsr,
   output logic [LONG_W-1:0]   rem_out,
   output logic [2*LONG_W-1:0] num_out
);
   logic [LONG_W:0] shifted;
   logic [LONG_W:0] diff;
   logic            take;

   always_comb begin
      shifted = {rem_in, num_in[2*LONG_W-1]};
      diff    = shifted - {1'b0, dsr};
      take    = ~diff[LONG_W];
      rem_out = take ? diff[LONG_W-1:0] : shifted[LONG_W-1:0];
      num_out = {num_in[2*LONG_W-2:0], take};
   end

endmodule

// File: rtl/iterdiv_finish.sv
module iterdiv_finish
   import iterdiv_pkg::*;
#(
   parameter int LONG_W = 32
) (
   input  logic [1:0]          op,
   input  logic [2*LONG_W-1:0] qmag,
   input  logic [LONG_W-1:0]   rmag,
   input  logic                neg_quo,
   input  logic                neg_rem,
   output logic                ovf,
   output logic [LONG_W-1:0]   word_pack,
   output logic [LONG_W-1:0]   quo_long,
   output logic [LONG_W-1:0]   rem_long,
   output logic                n_flag,
   output logic                z_flag
);
   localparam int SW = LONG_W / 2;
   localparam int NW = 2 * LONG_W;
   localparam logic [NW-1:0] LONG_BOUND = NW'(1) << (LONG_W - 1);
   localparam logic [NW-1:0] WORD_BOUND = NW'(1) << (SW - 1);

   logic [LONG_W-1:0] qs;
   logic [LONG_W-1:0] rs;
   logic [NW-1:0]     bound;
   logic              is_long;

   always_comb begin
      is_long = op[OP_LONG_BIT];
      qs      = neg_quo ? -qmag[LONG_W-1:0] : qmag[LONG_W-1:0];
      rs      = neg_rem ? -rmag : rmag;
      bound   = is_long ? LONG_BOUND : WORD_BOUND;
      if (op[OP_SIGNED_BIT])
         ovf = neg_quo ? (qmag > bound) : (qmag >= bound);
      else
         ovf = is_long ? (|qmag[NW-1:LONG_W]) : (|qmag[NW-1:SW]);
      n_flag    = is_long ? qs[LONG_W-1] : qs[SW-1];
      z_flag    = is_long ? (qs == '0) : (qs[SW-1:0] == '0);
      word_pack = {rs[SW-1:0], qs[SW-1:0]};
      quo_long  = qs;
      rem_long  = rs;
   end

endmodule

// File: rtl/iter_divider.sv
module iter_divider
   import iterdiv_pkg::*;
#(
   parameter int LONG_W = 32,
   parameter int IDX_W  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [1:0]        op,
   input  logic [LONG_W-1:0] dvd_hi,
   input  logic [LONG_W-1:0] dvd_lo,
   input  logic [LONG_W-1:0] divisor,
   input  logic [IDX_W-1:0]  quot_idx,
   input  logic [IDX_W-1:0]  rem_idx,
   output logic              busy,
   output logic              done,
   output logic              div0_req,
   output logic              wr_en,
   output logic [IDX_W-1:0]  wr_idx,
   output logic [LONG_W-1:0] wr_data,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_v,
   output logic              flag_c
);
   localparam int NUM_W = 2 * LONG_W;
   localparam int CNT_W = $clog2(NUM_W + 1);

   generate
      if (LONG_W < 4 || (LONG_W % 2) != 0) begin : g_bad_long_w
         $error("iter_divider: LONG_W must be even and at least 4");
      end
      if (IDX_W < 1) begin : g_bad_idx_w
         $error("iter_divider: IDX_W must be at least 1");
      end
   endgenerate

   div_state_e        state;
   logic [CNT_W-1:0]  cnt;
   logic [NUM_W-1:0]  num_q;
   logic [LONG_W-1:0] rem_q;
   logic [LONG_W-1:0] dsr_q;
   logic [1:0]        op_q;
   logic              negq_q;
   logic              negr_q;
   logic [IDX_W-1:0]  qidx_q;
   logic [IDX_W-1:0]  ridx_q;
   logic [LONG_W-1:0] quot_hold;

   logic [NUM_W-1:0]  p_num;
   logic [LONG_W-1:0] p_dsr;
   logic              p_negq;
   logic              p_negr;
   logic              p_zero;

   logic [NUM_W-1:0]  s_num;
   logic [LONG_W-1:0] s_rem;

   logic              f_ovf;
   logic [LONG_W-1:0] f_pack;
   logic [LONG_W-1:0] f_quo;
   logic [LONG_W-1:0] f_rem;
   logic              f_n;
   logic              f_z;

   iterdiv_prep #(.LONG_W(LONG_W)) u_prep (
      .op       (op),
      .hi       (dvd_hi),
      .lo       (dvd_lo),
      .dsr      (divisor),
      .num_mag  (p_num),
      .dsr_mag  (p_dsr),
      .neg_quo  (p_negq),
      .neg_rem  (p_negr),
      .dsr_zero (p_zero)
   );

   iterdiv_step #(.LONG_W(LONG_W)) u_step (
      .rem_in  (rem_q),
      .num_in  (num_q),
      .dsr     (dsr_q),
      .rem_out (s_rem),
      .num_out (s_num)
   );

   iterdiv_finish #(.LONG_W(LONG_W)) u_finish (
      .op        (op_q),
      .qmag      (num_q),
      .rmag      (rem_q),
      .neg_quo   (negq_q),
      .neg_rem   (negr_q),
      .ovf       (f_ovf),
      .word_pack (f_pack),
      .quo_long  (f_quo),
      .rem_long  (f_rem),
      .n_flag    (f_n),
      .z_flag    (f_z)
   );

   assign busy = (state != ST_IDLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         cnt       <= '0;
         num_q     <= '0;
         rem_q     <= '0;
         dsr_q     <= '0;
         op_q      <= '0;
         negq_q    <= 1'b0;
         negr_q    <= 1'b0;
         qidx_q    <= '0;
         ridx_q    <= '0;
         quot_hold <= '0;
         done      <= 1'b0;
         div0_req  <= 1'b0;
         wr_en     <= 1'b0;
         wr_idx    <= '0;
         wr_data   <= '0;
         flag_n    <= 1'b0;
         flag_z    <= 1'b0;
         flag_v    <= 1'b0;
         flag_c    <= 1'b0;
      end else begin
         done     <= 1'b0;
         div0_req <= 1'b0;
         wr_en    <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (start) begin
                  if (p_zero) begin
                     div0_req <= 1'b1;
                     done     <= 1'b1;
                  end else begin
                     num_q  <= p_num;
                     rem_q  <= '0;
                     dsr_q  <= p_dsr;
                     op_q   <= op;
                     negq_q <= p_negq;
                     negr_q <= p_negr;
                     qidx_q <= quot_idx;
                     ridx_q <= rem_idx;
                     cnt    <= op[OP_LONG_BIT] ? CNT_W'(NUM_W) : CNT_W'(LONG_W);
                     state  <= ST_RUN;
                  end
               end
            end
            ST_RUN: begin
               num_q <= s_num;
               rem_q <= s_rem;
               cnt   <= cnt - 1'b1;
               if (cnt == CNT_W'(1))
                  state <= ST_FIX;
            end
            ST_FIX: begin
               done   <= 1'b1;
               flag_c <= 1'b0;
               state  <= ST_IDLE;
               if (f_ovf) begin
                  flag_v <= 1'b1;
                  flag_z <= 1'b0;
               end else begin
                  flag_v <= 1'b0;
                  flag_z <= f_z;
                  flag_n <= f_n;
                  wr_en  <= 1'b1;
                  if (op_q[OP_LONG_BIT]) begin
                     wr_idx    <= ridx_q;
                     wr_data   <= f_rem;
                     quot_hold <= f_quo;
                     state     <= ST_WRQ;
                  end else begin
                     wr_idx  <= qidx_q;
                     wr_data <= f_pack;
                  end
               end
            end
            ST_WRQ: begin
               wr_en   <= 1'b1;
               wr_idx  <= qidx_q;
               wr_data <= quot_hold;
               state   <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/iterdiv_checker.sv
module iterdiv_checker (
   input logic clk,
   input logic rst_n,
   input logic busy,
   input logic done,
   input logic div0_req,
   input logic wr_en,
   input logic flag_n,
   input logic flag_z,
   input logic flag_v
);

   // R2: a divide-by-zero request comes with done and never with a write
   assert_div0_nowrite_R2: assert property (@(posedge clk) disable iff (!rst_n)
      div0_req |-> (done && !wr_en));

   // R5: an overflowing operation writes nothing
   assert_ovf_nowrite_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flag_v) |-> !wr_en);

   // R5: Z is clear whenever V is reported
   assert_ovf_zclear_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flag_v) |-> !flag_z);

   // R5: N keeps its previous value on overflow
   assert_ovf_nhold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flag_v && !div0_req) |-> (flag_n == $past(flag_n)));

   // R8: a write made while still busy (remainder) is followed by the final quotient write
   assert_rem_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && busy) |=> (wr_en && !busy));

endmodule

bind iter_divider iterdiv_checker u_iterdiv_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .done     (done),
   .div0_req (div0_req),
   .wr_en    (wr_en),
   .flag_n   (flag_n),
   .flag_z   (flag_z),
   .flag_v   (flag_v)
);

// File: tb/test_iter_divider.sv
`timescale 1ns/1ps
module test_iter_divider;
   localparam int LW = 8;
   localparam int SW = LW / 2;
   localparam int IW = 3;
   localparam int CYCLE_LIMIT = 195000;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          start;
   logic [1:0]    op;
   logic [LW-1:0] dvd_hi, dvd_lo, divisor;
   logic [IW-1:0] quot_idx, rem_idx;
   logic          busy, done, div0_req, wr_en;
   logic [IW-1:0] wr_idx;
   logic [LW-1:0] wr_data;
   logic          flag_n, flag_z, flag_v, flag_c;

   int vecs = 0;
   int errs = 0;
   int cycles = 0;
   bit finished = 0;
   logic [LW-1:0] rf [8];

   always #2.5 clk = ~clk;

   iter_divider #(.LONG_W(LW), .IDX_W(IW)) i_iter_divider (
      .clk(clk), .rst_n(rst_n), .start(start), .op(op),
      .dvd_hi(dvd_hi), .dvd_lo(dvd_lo), .divisor(divisor),
      .quot_idx(quot_idx), .rem_idx(rem_idx),
      .busy(busy), .done(done), .div0_req(div0_req),
      .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v), .flag_c(flag_c)
   );

   task automatic report;
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
   endtask

   always @(posedge clk) begin
      cycles++;
      if (cycles == CYCLE_LIMIT && !finished) begin
         errs++;
         $display("FAIL watchdog R11: actual=hung expected=done within %0d cycles", CYCLE_LIMIT);
         finished = 1;
         report();
         $finish;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      if (act !== exp) begin
         errs++;
         $display("FAIL %s: actual=%0h expected=%0h (op=%0d hi=%0h lo=%0h d=%0h)",
                  tag, act, exp, op, dvd_hi, dvd_lo, divisor);
      end
   endtask

   task automatic run_op(input logic [1:0] o, input logic [LW-1:0] hi, input logic [LW-1:0] lo,
                         input logic [LW-1:0] d, input int qi, input int ri, input bit poke);
      longint n, dd, q, r, lim;
      logic [63:0] qv, rv;
      bit dz, ovf, seen_done, seen_div0;
      int w, lat, done_lat;
      logic pn, fn, fz, fv, fc;
      logic [LW-1:0] exp_q, exp_r, sent_q, sent_r;
      string ftag, rtag;

      w = o[1] ? LW : SW;
      case (o)
         2'd0: begin n = longint'(lo); dd = longint'(d[SW-1:0]); end
         2'd1: begin n = longint'($signed(lo)); dd = longint'($signed(d[SW-1:0])); end
         2'd2: begin n = longint'({hi, lo}); dd = longint'(d); end
         default: begin n = longint'($signed({hi, lo})); dd = longint'($signed(d)); end
      endcase
      dz = (dd == 0);
      q = 0; r = 0; ovf = 0;
      if (!dz) begin
         q = n / dd;            // truncation toward zero (R10)
         r = n % dd;
         lim = longint'(1) << (w - 1);
         if (o[0]) ovf = (q > lim - 1) || (q < -lim);
         else      ovf = (q > (longint'(1) << w) - 1);
      end
      qv = q; rv = r;

      rf[qi] = 8'hA5;
      rf[ri] = 8'h5A;
      sent_q = rf[qi];
      sent_r = rf[ri];
      exp_q = sent_q; exp_r = sent_r;
      if (!dz && !ovf) begin
         if (o[1]) begin
            exp_r = rv[LW-1:0];
            if (qi == ri) exp_r = qv[LW-1:0];
            exp_q = qv[LW-1:0];
         end else begin
            exp_q = {rv[SW-1:0], qv[SW-1:0]};
            if (qi == ri) exp_r = exp_q;
         end
      end

      @(negedge clk);
      pn = flag_n;
      op = o; dvd_hi = hi; dvd_lo = lo; divisor = d;
      quot_idx = IW'(qi); rem_idx = IW'(ri);
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      lat = 1; seen_done = 0; seen_div0 = 0; done_lat = 0;
      fn = 0; fz = 0; fv = 0; fc = 0;
      forever begin
         if (wr_en) rf[wr_idx] = wr_data;
         if (div0_req) seen_div0 = 1;
         if (done && !seen_done) begin
            seen_done = 1; done_lat = lat;
            fn = flag_n; fz = flag_z; fv = flag_v; fc = flag_c;
         end
         if (seen_done && !busy) break;
         // R1: a start while busy must be ignored; offer one with a zero divisor
         if (poke && lat == 3) begin start = 1'b1; divisor = '0; op = ~o; end
         else start = 1'b0;
         @(negedge clk);
         lat++;
      end
      start = 1'b0;
      vecs++;

      chk("R11 latency", 64'(done_lat), dz ? 64'd1 : (o[1] ? 64'(2*LW+2) : 64'(LW+2)));
      chk(poke ? "R1 start-while-busy request" : "R2 div0_req", 64'(seen_div0), 64'(dz));
      if (dz) begin
         chk("R2 flags unchanged", {fn, fz, fv, fc}, {pn, 1'b0, 1'b0, 1'b0} | {1'b0, fz, fv, 1'b0});
         chk("R2 flag_c", 64'(fc), 64'd0);
      end else begin
         chk("R6 flag_c", 64'(fc), 64'd0);
         ftag = o[1] ? "R7 overflow" : "R4 overflow";
         chk(ftag, 64'(fv), 64'(ovf));
         if (ovf) begin
            chk("R5 flag_z", 64'(fz), 64'd0);
            chk("R5 flag_n", 64'(fn), 64'(pn));
         end else begin
            chk("R9 flag_n", 64'(fn), 64'(qv[w-1]));
            chk("R9 flag_z", 64'(fz), 64'((qv & ((64'd1 << w) - 1)) == 0));
         end
      end
      if (dz)              rtag = "R2 reg";
      else if (ovf)        rtag = "R5 reg";
      else if (o[0])       rtag = "R10 reg";
      else if (o[1])       rtag = "R8 reg";
      else                 rtag = "R3 reg";
      chk(rtag, 64'(rf[qi]), 64'(exp_q));
      chk(rtag, 64'(rf[ri]), 64'(exp_r));
   endtask

   initial begin
      logic [31:0] s;
      logic [LW-1:0] h, l, d;
      rst_n = 1'b0; start = 1'b0; op = '0;
      dvd_hi = '0; dvd_lo = '0; divisor = '0; quot_idx = '0; rem_idx = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R12: reset state
      vecs++;
      chk("R12 reset outputs", {busy, done, div0_req, wr_en, flag_n, flag_z, flag_v, flag_c}, 64'd0);

      // R3 R4 R9 R10: every operand pair of both word forms (op 0 unsigned, op 1 signed)
      for (int o = 0; o < 2; o++)
         for (int lo = 0; lo < 256; lo++)
            for (int dv = 0; dv < 16; dv++)
               run_op(2'(o), '0, 8'(lo), 8'(dv), (lo + dv) % 8, (lo * 3 + dv) % 8, 0);

      // R7 R8: long forms (op 2 unsigned, op 3 signed), corners then mixed operands
      run_op(2'd3, 8'h80, 8'h00, 8'hFF, 1, 2, 0);
      run_op(2'd3, 8'hFF, 8'h80, 8'h01, 3, 3, 0);
      run_op(2'd2, 8'h00, 8'hFF, 8'h00, 4, 5, 0);
      run_op(2'd2, 8'hFE, 8'hFF, 8'hFF, 6, 6, 0);
      s = 32'h1234_5678;
      for (int k = 0; k < 1400; k++) begin
         s = s * 32'd1103515245 + 32'd12345;
         l = s[23:16];
         d = s[15:8];
         case (k % 4)
            0: h = s[31:24];
            1: h = {LW{l[LW-1]}};
            2: h = (d == 0) ? '0 : 8'(s[31:24] % d);
            default: h = s[31:24] & 8'h07;
         endcase
         run_op(2'd2 + 2'(k % 2), h, l, d, k % 8, (k / 8) % 8, (k % 50) == 7);
      end

      finished = 1;
      report();
      $finish;
   end

endmodule